// File: doc/BRIEF.md
# Host Interrupt Status Controller

This block collects interrupt events from device-side logic and presents them to a host processor through a small register window. Each event source delivers a one-cycle pulse. The pulse sets a sticky bit in a status vector. That bit stays set until the host clears it. Only the bit positions enabled by the `SRC_MASK` parameter hold state. All other positions are tied to zero.

The host has two ways to read the status vector. A peek read leaves the vector unchanged. A pop read returns the vector and clears all of it at the same clock edge. The host can also clear individual bits by writing ones to an acknowledge register. A mask vector suppresses chosen events toward the host. The host can load the mask as a whole, or change single bits through write-one set and clear registers.

The host interrupt pin carries a level. That level is the OR of all status bits whose mask bit is clear. Two configuration bits set the pin behaviour: one enables it and one selects active-low signalling. When the pin is disabled it rests at its inactive level. The pin can be taken straight from the registers or through one output flop.

Top module: `hirq_ctrl`

## Requirements
- R1: Out of reset the mask holds `MASK_RST` (default 0x0001, bit 0 masked), the status vector and both configuration bits are zero, and the interrupt pin is low.
- R2: A write to word address 0 loads the mask from the write data. A read of word address 0 returns the mask.
- R3: Writing to word address 1 sets every mask bit whose write-data bit is one. Mask bits at zero positions of the write data keep their value.
- R4: Writing to word address 2 clears every mask bit whose write-data bit is one. Mask bits at zero positions of the write data keep their value.
- R5: A read of word address 3 returns the status vector and does not change it.
- R6: A read of word address 4 returns the status vector and clears the whole vector at that clock edge.
- R7: Writing to word address 5 clears every status bit whose write-data bit is one. Status bits at zero positions of the write data keep their value.
- R8: A source pulse on a position enabled in `SRC_MASK` sets that status bit at the next edge, whatever the mask holds. With the default `SRC_MASK`, the enabled positions are bits 0 to 10, 14, 16 and 17. Positions outside `SRC_MASK` always read as zero.
- R9: A source pulse wins over an acknowledge or pop of the same bit in the same cycle, so the bit is set after that edge.
- R10: Word address 6 holds the configuration. Bit 0 enables the pin and bit 1 selects active-low. The pin equals the OR of (status AND NOT mask), inverted when active-low. When the pin is disabled it holds the inactive level (low when active-high, high when active-low). With `REG_OUT`=1 the pin follows register state one cycle later.
- R11: Reads of word addresses 1, 2, 5 and 7 return zero. Read data is zero while the read strobe is low. Writes to word addresses 3, 4 and 7 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_pulse_i | input | STAT_W | One-cycle event pulses from the sources |
| bus_addr_i | input | AW | Word address of the register access |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rd_i | input | 1 | Read strobe |
| bus_rdata_o | output | DATA_W | Read data, valid in the same cycle as the read strobe |
| host_irq_o | output | 1 | Host interrupt pin |

## Verification
The bench builds the block with `STAT_W`=18, so the two source positions above the low sixteen are exercised. It uses the default sparse `SRC_MASK`, so pulses on the unused positions 11 to 13 and 15 can be shown to latch nothing. It also sets `REG_OUT`=1, so every pin check covers the extra flop delay together with both polarities and the disabled state. Random traffic mixes sparse source pulses with all seven register actions. Directed cases then line up a pulse against an acknowledge and against a pop of the same bit.

// File: rtl/hirq_pkg.sv
package hirq_pkg;

   typedef enum logic [2:0] {
      REG_MASK     = 3'd0,
      REG_MASK_SET = 3'd1,
      REG_MASK_CLR = 3'd2,
      REG_PEEK     = 3'd3,
      REG_POP      = 3'd4,
      REG_ACK      = 3'd5,
      REG_CFG      = 3'd6,
      REG_NONE     = 3'd7
   } hirq_reg_e;

   typedef struct packed {
      logic wr_mask;
      logic wr_set;
      logic wr_clr;
      logic wr_ack;
      logic wr_cfg;
      logic rd_pop;
   } hirq_strb_t;

   localparam int unsigned CFG_EN_BIT  = 0;
   localparam int unsigned CFG_LOW_BIT = 1;
   localparam int unsigned CFG_W       = 2;

endpackage

// File: rtl/hirq_regdec.sv
module hirq_regdec
   import hirq_pkg::*;
#(
   parameter int unsigned AW = 4
) (
   input  logic [AW-1:0] addr_i,
   input  logic          wr_i,
   input  logic          rd_i,
   output hirq_strb_t    strb_o,
   output hirq_reg_e     rsel_o
);

   logic      in_window;
   hirq_reg_e sel;

   assign in_window = ((addr_i >> 3) == '0);
   assign sel       = in_window ? hirq_reg_e'(addr_i[2:0]) : REG_NONE;
   assign rsel_o    = rd_i ? sel : REG_NONE;

   always_comb begin
      strb_o = '0;
      if (wr_i) begin
         unique case (sel)
            REG_MASK:     strb_o.wr_mask = 1'b1;
            REG_MASK_SET: strb_o.wr_set  = 1'b1;
            REG_MASK_CLR: strb_o.wr_clr  = 1'b1;
            REG_ACK:      strb_o.wr_ack  = 1'b1;
            REG_CFG:      strb_o.wr_cfg  = 1'b1;
            default:      ;
         endcase
      end
      if (rd_i && sel == REG_POP) strb_o.rd_pop = 1'b1;
   end

endmodule

// File: rtl/hirq_mask_reg.sv
module hirq_mask_reg #(
   parameter int unsigned     STAT_W   = 18,
   parameter logic [STAT_W-1:0] MASK_RST = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              set_i,
   input  logic              clr_i,
   input  logic [STAT_W-1:0] data_i,
   output logic [STAT_W-1:0] mask_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mask_o <= MASK_RST;
      else if (load_i) mask_o <= data_i;
      else if (set_i)  mask_o <= mask_o | data_i;
      else if (clr_i)  mask_o <= mask_o & ~data_i;
   end

endmodule

// File: rtl/hirq_status.sv
module hirq_status #(
   parameter int unsigned       STAT_W   = 18,
   parameter logic [STAT_W-1:0] SRC_MASK = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STAT_W-1:0] pulse_i,
   input  logic [STAT_W-1:0] clr_i,
   output logic [STAT_W-1:0] stat_o
);

   for (genvar b = 0; b < STAT_W; b++) begin : g_bit
      if (SRC_MASK[b]) begin : g_live
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          q <= 1'b0;
            else if (pulse_i[b]) q <= 1'b1;
            else if (clr_i[b])   q <= 1'b0;
         end
         assign stat_o[b] = q;
      end else begin : g_tied
         assign stat_o[b] = 1'b0;
      end
   end

endmodule

// File: rtl/hirq_pin.sv
module hirq_pin #(
   parameter int unsigned STAT_W  = 18,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STAT_W-1:0] stat_i,
   input  logic [STAT_W-1:0] mask_i,
   input  logic              en_i,
   input  logic              low_i,
   output logic              pin_o
);

   logic pending;
   logic drive;

   assign pending = |(stat_i & ~mask_i);
   assign drive   = en_i ? (pending ^ low_i) : low_i;

   if (REG_OUT) begin : g_flop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pin_o <= 1'b0;
         else        pin_o <= drive;
      end
   end else begin : g_direct
      assign pin_o = drive;
   end

endmodule

// File: rtl/hirq_ctrl.sv
module hirq_ctrl
   import hirq_pkg::*;
#(
   parameter int unsigned       AW       = 4,
   parameter int unsigned       DATA_W   = 32,
   parameter int unsigned       STAT_W   = 18,
   parameter logic [STAT_W-1:0] SRC_MASK = 18'h347FF,
   parameter logic [STAT_W-1:0] MASK_RST = 18'h00001,
   parameter bit                REG_OUT  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STAT_W-1:0] src_pulse_i,
   input  logic [AW-1:0]     bus_addr_i,
   input  logic              bus_wr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   input  logic              bus_rd_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic              host_irq_o
);

   if (AW < 3) begin : g_chk_aw
      $error("hirq_ctrl: AW must be at least 3");
   end
   if (STAT_W > DATA_W) begin : g_chk_w
      $error("hirq_ctrl: STAT_W must not exceed DATA_W");
   end
   if (STAT_W < 1) begin : g_chk_s
      $error("hirq_ctrl: STAT_W must be positive");
   end

   hirq_strb_t        strb;
   hirq_reg_e         rsel;
   logic [STAT_W-1:0] wbits;
   logic [STAT_W-1:0] mask_q;
   logic [STAT_W-1:0] stat_q;
   logic [STAT_W-1:0] clr_vec;
   logic [CFG_W-1:0]  cfg_q;

   assign wbits = bus_wdata_i[STAT_W-1:0];

   hirq_regdec #(.AW(AW)) i_dec (
      .addr_i (bus_addr_i),
      .wr_i   (bus_wr_i),
      .rd_i   (bus_rd_i),
      .strb_o (strb),
      .rsel_o (rsel)
   );

   hirq_mask_reg #(.STAT_W(STAT_W), .MASK_RST(MASK_RST)) i_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (strb.wr_mask),
      .set_i  (strb.wr_set),
      .clr_i  (strb.wr_clr),
      .data_i (wbits),
      .mask_o (mask_q)
   );

   assign clr_vec = (strb.wr_ack ? wbits : '0) | {STAT_W{strb.rd_pop}};

   hirq_status #(.STAT_W(STAT_W), .SRC_MASK(SRC_MASK)) i_stat (
      .clk     (clk),
      .rst_n   (rst_n),
      .pulse_i (src_pulse_i),
      .clr_i   (clr_vec),
      .stat_o  (stat_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cfg_q <= '0;
      else if (strb.wr_cfg) cfg_q <= bus_wdata_i[CFG_W-1:0];
   end

   hirq_pin #(.STAT_W(STAT_W), .REG_OUT(REG_OUT)) i_pin (
      .clk    (clk),
      .rst_n  (rst_n),
      .stat_i (stat_q),
      .mask_i (mask_q),
      .en_i   (cfg_q[CFG_EN_BIT]),
      .low_i  (cfg_q[CFG_LOW_BIT]),
      .pin_o  (host_irq_o)
   );

   always_comb begin
      unique case (rsel)
         REG_MASK:          bus_rdata_o = DATA_W'(mask_q);
         REG_PEEK, REG_POP: bus_rdata_o = DATA_W'(stat_q);
         REG_CFG:           bus_rdata_o = DATA_W'(cfg_q);
         default:           bus_rdata_o = '0;
      endcase
   end

endmodule

// File: rtl/hirq_ctrl_chk.sv
module hirq_ctrl_chk #(
   parameter int unsigned       AW       = 4,
   parameter int unsigned       DATA_W   = 32,
   parameter int unsigned       STAT_W   = 18,
   parameter logic [STAT_W-1:0] SRC_MASK = '1,
   parameter bit                REG_OUT  = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [STAT_W-1:0] src_pulse_i,
   input logic [AW-1:0]     bus_addr_i,
   input logic              bus_wr_i,
   input logic [DATA_W-1:0] bus_wdata_i,
   input logic              bus_rd_i,
   input logic [DATA_W-1:0] bus_rdata_o,
   input logic              host_irq_o,
   input logic [STAT_W-1:0] mask_q,
   input logic [STAT_W-1:0] stat_q,
   input logic [1:0]        cfg_q
);

   logic [STAT_W-1:0] wb;
   logic [STAT_W-1:0] live_src;
   logic              at_set, at_clr, at_peek, at_pop, at_ack, at_wo;

   assign wb       = bus_wdata_i[STAT_W-1:0];
   assign live_src = src_pulse_i & SRC_MASK;
   assign at_set   = (bus_addr_i == AW'(1));
   assign at_clr   = (bus_addr_i == AW'(2));
   assign at_peek  = (bus_addr_i == AW'(3));
   assign at_pop   = (bus_addr_i == AW'(4));
   assign at_ack   = (bus_addr_i == AW'(5));
   assign at_wo    = at_set || at_clr || at_ack || (bus_addr_i == AW'(7));

   assert_mask_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_i && at_set) |=> (mask_q == ($past(mask_q) | $past(wb))));

   assert_mask_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_i && at_clr) |=> (mask_q == ($past(mask_q) & ~$past(wb))));

   assert_peek_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd_i && at_peek && !bus_wr_i) |=> (stat_q == ($past(stat_q) | $past(live_src))));

   assert_pop_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd_i && at_pop) |=> (stat_q == $past(live_src)));

   assert_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_i && at_ack && !bus_rd_i) |=> (stat_q == (($past(stat_q) & ~$past(wb)) | $past(live_src))));

   assert_unused_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_q & ~SRC_MASK) == '0));

   assert_src_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (live_src != '0) |=> ((stat_q & $past(live_src)) == $past(live_src)));

   assert_wo_reads_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd_i && at_wo) |-> (bus_rdata_o == '0));

   if (REG_OUT) begin : g_pin_reg
      assert_pin_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (host_irq_o == ($past(cfg_q[0])
                   ? ((|($past(stat_q) & ~$past(mask_q))) ^ $past(cfg_q[1]))
                   : $past(cfg_q[1]))));
   end else begin : g_pin_comb
      assert_pin_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
         host_irq_o == (cfg_q[0] ? ((|(stat_q & ~mask_q)) ^ cfg_q[1]) : cfg_q[1]));
   end

endmodule

bind hirq_ctrl hirq_ctrl_chk #(
   .AW(AW), .DATA_W(DATA_W), .STAT_W(STAT_W), .SRC_MASK(SRC_MASK), .REG_OUT(REG_OUT)
) i_hirq_ctrl_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .src_pulse_i (src_pulse_i),
   .bus_addr_i  (bus_addr_i),
   .bus_wr_i    (bus_wr_i),
   .bus_wdata_i (bus_wdata_i),
   .bus_rd_i    (bus_rd_i),
   .bus_rdata_o (bus_rdata_o),
   .host_irq_o  (host_irq_o),
   .mask_q      (mask_q),
   .stat_q      (stat_q),
   .cfg_q       (cfg_q)
);

// File: tb/test_hirq_ctrl.sv
module test_hirq_ctrl;

   localparam int unsigned       AW     = 4;
   localparam int unsigned       DW     = 32;
   localparam int unsigned       SW     = 18;
   localparam logic [SW-1:0]     SRCM   = 18'h347FF;
   localparam logic [SW-1:0]     MRST   = 18'h00001;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [SW-1:0] src = '0;
   logic [AW-1:0] addr = '0;
   logic          wr = 1'b0;
   logic [DW-1:0] wdata = '0;
   logic          rd = 1'b0;
   logic [DW-1:0] rdata;
   logic          irq;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   logic [SW-1:0] m_mask;
   logic [SW-1:0] m_stat;
   logic [1:0]    m_cfg;

   always #2 clk = ~clk;

   hirq_ctrl #(
      .AW(AW), .DATA_W(DW), .STAT_W(SW), .SRC_MASK(SRCM), .MASK_RST(MRST), .REG_OUT(1'b1)
   ) i_hirq_ctrl (
      .clk(clk), .rst_n(rst_n), .src_pulse_i(src), .bus_addr_i(addr),
      .bus_wr_i(wr), .bus_wdata_i(wdata), .bus_rd_i(rd),
      .bus_rdata_o(rdata), .host_irq_o(irq)
   );

   function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a);
      case (a)
         4'd0:       return DW'(m_mask);
         4'd3, 4'd4: return DW'(m_stat);
         4'd6:       return DW'(m_cfg);
         default:    return '0;
      endcase
   endfunction

   function automatic logic exp_pin();
      logic lvl;
      lvl = |(m_stat & ~m_mask);
      return m_cfg[0] ? (lvl ^ m_cfg[1]) : m_cfg[1];
   endfunction

   function automatic string req_of(input logic [AW-1:0] a);
      case (a)
         4'd0:       return "R2";
         4'd3:       return "R5";
         4'd4:       return "R6";
         4'd6:       return "R10";
         default:    return "R11";
      endcase
   endfunction

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one bus cycle; called at a negedge, returns at the next negedge
   task automatic cycle(input logic w, input logic r, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input logic [SW-1:0] s);
      logic          pin_next;
      logic [SW-1:0] clr;
      src = s; wr = w; rd = r; addr = a; wdata = d;
      #1;
      if (r) check(req_of(a), rdata, exp_read(a));
      pin_next = exp_pin();
      clr = '0;
      if (w && a == 4'd5) clr = d[SW-1:0];
      if (r && a == 4'd4) clr = '1;
      if (w && a == 4'd0) m_mask = d[SW-1:0];
      if (w && a == 4'd1) m_mask = m_mask | d[SW-1:0];
      if (w && a == 4'd2) m_mask = m_mask & ~d[SW-1:0];
      if (w && a == 4'd6) m_cfg = d[1:0];
      m_stat = (m_stat & ~clr) | (s & SRCM);
      @(negedge clk);
      check("R10", DW'(irq), DW'(pin_next));
      src = '0; wr = 1'b0; rd = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      m_mask = MRST; m_stat = '0; m_cfg = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1", DW'(irq), 0);
      cycle(0, 1, 4'd0, 0, 0);
      check("R1", DW'(m_mask), DW'(MRST));
      cycle(0, 1, 4'd3, 0, 0);
      cycle(0, 1, 4'd6, 0, 0);

      // enable pin, active-high
      cycle(1, 0, 4'd6, 32'h1, 0);
      // R8 unused bits never latch, masked bit 0 still latches
      cycle(0, 0, 4'd0, 0, 18'h0B801);
      cycle(0, 1, 4'd3, 0, 0);
      check("R8", DW'(m_stat), 32'h1);
      // R9 source beats acknowledge of same bit
      cycle(1, 0, 4'd5, 32'h1, 18'h1);
      cycle(0, 1, 4'd3, 0, 0);
      check("R9", DW'(m_stat), 32'h1);
      // R9 source beats pop
      cycle(0, 1, 4'd4, 0, 18'h20000);
      cycle(0, 1, 4'd3, 0, 0);
      check("R9", DW'(m_stat), 32'h20000);
      // R3 / R4 single-bit edits with active-low pin
      cycle(1, 0, 4'd6, 32'h3, 0);
      cycle(1, 0, 4'd1, 32'h20000, 0);
      cycle(0, 1, 4'd0, 0, 0);
      cycle(1, 0, 4'd2, 32'h20001, 0);
      cycle(0, 1, 4'd0, 0, 0);
      cycle(0, 0, 4'd0, 0, 0);
      // R11 write to status aliases has no effect
      cycle(1, 0, 4'd3, 32'h0, 0);
      cycle(1, 0, 4'd4, 32'h0, 0);
      cycle(0, 1, 4'd3, 0, 0);

      // random traffic
      for (int i = 0; i < 4000; i++) begin
         logic [3:0]    op;
         logic [SW-1:0] s;
         logic [DW-1:0] d;
         op = 4'($urandom_range(0, 9));
         s  = SW'($urandom & $urandom & $urandom);
         d  = $urandom;
         if (op < 3)       cycle(0, 0, 4'd0, 0, s);
         else if (op < 6)  cycle(1, 0, 4'($urandom_range(0, 8)), d, s);
         else              cycle(0, 1, 4'($urandom_range(0, 8)), 0, s);
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule